// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

When reset is released, this block reads a three-wire serial EEPROM word by word and loads the adapter's startup settings from it. The header words give a byte count, a 16-bit configuration word and a six-byte station address. A stored check byte is compared against a locally computed byte sum, and the result is reported. After the header, every remaining word from address 0x10 up to the last word of the device goes out on a simple write port into attribute memory. The chip-level logic holds host accesses off while `busy` is high. It uses the loaded fields once `done` rises.

A strap input gives the device size, which sets the number of address bits in each read command. The serial clock is made by dividing the system clock. With the default divider it stays at or below 1 MHz for a 125 MHz system clock.

Top module: `eeprom_boot_loader`

## Requirements
- R1: While `rst` is high, `busy`, `done` and `ee_cs` are low. On the first rising clock edge with `rst` low after it was high, `busy` goes high and a load begins. `ee_cs` is never high while `busy` is low.
- R2: Each word read holds `ee_cs` high and sends the opcode bits 1,1,0 followed by the word address, most significant bit first. The address is 6 bits when the latched strap is 0 and 8 bits when it is 1. `ee_di` changes only while `ee_sk` is low. Sixteen data bits, most significant first, are then taken from `ee_do` on the `ee_sk` falling edges that follow the dummy bit.
- R3: Each high phase and each low phase of `ee_sk` inside a word lasts exactly HALF_PER system clocks. `ee_sk` is low whenever `ee_cs` is low. `ee_cs` stays low for at least two clocks between words.
- R4: The strap is latched when the load starts. A value of 0 reads words 0x00–0x05 and 0x10–0x3F. A value of 1 reads words 0x00–0x05 and 0x10–0x7F. Words are read in ascending order, and any change of the strap during a load has no effect.
- R5: `word_count` receives the low byte of word 0x00.
- R6: `cfg_word` receives word 0x01, and `pwr_down` equals bit 0 of that word.
- R7: `node_id[15:0]`, `[31:16]` and `[47:32]` receive words 0x02, 0x03 and 0x04. Byte n of the address therefore sits at bits 8n+7:8n.
- R8: `csum_ok` is 1 exactly when the high byte of word 0x05 equals the modulo-256 sum of the ten bytes of words 0x00–0x04.
- R9: Each word at address 0x10 or above produces exactly one single-cycle `cis_we` pulse. The pulse carries `cis_addr` = word address − 0x10 and `cis_data` = the word, in ascending order. No other pulses occur, and `cis_we` is only high while `busy` is high.
- R10: After the last word, `busy` falls and `done` rises on the same edge whatever the checksum result. `done` then holds until the next reset, and `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; its falling edge starts a load |
| size_strap | input | 1 | 0 = 128-byte device, 1 = 256-byte device |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished |
| word_count | output | 8 | Loaded count byte |
| cfg_word | output | 16 | Loaded configuration word |
| pwr_down | output | 1 | Power-down enable from the configuration word |
| node_id | output | 48 | Loaded station address |
| csum_ok | output | 1 | Header checksum matched |
| cis_we | output | 1 | Attribute-memory write strobe |
| cis_addr | output | 7 | Attribute-memory word index |
| cis_data | output | 16 | Attribute-memory write data |

## Verification
The bench runs three loads. The first uses the large device with a correct check byte and power-down enabled. The second uses the small device with a wrong check byte and the strap flipped to 1 partway through; it shows that the strap is latched and that `done` rises on a failed checksum. The third uses the small device with a correct check byte and a different fill pattern. Each image is built from an address-dependent pattern, so a wrong address width, a shifted bit or a swapped byte lands on a different value. The EEPROM model checks every opcode and address it receives, and the scoreboard checks the order and count of the attribute writes.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned OPC_BITS = 3;
  localparam logic [2:0]  OPC_READ = 3'b110;
  localparam logic [6:0]  HDR_CSUM = 7'h05;
  localparam logic [6:0]  CIS_FIRST = 7'h10;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} seq_st_t;
  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_st_t;

  // address bits per read command for the given size strap
  function automatic logic [4:0] addr_bits(input logic big);
    return big ? 5'd8 : 5'd6;
  endfunction

  // highest word address of the device
  function automatic logic [6:0] last_word(input logic big);
    return big ? 7'd127 : 7'd63;
  endfunction

  // running modulo-256 byte sum
  function automatic logic [7:0] byte_sum(input logic [7:0] acc, input logic [15:0] w);
    return acc + w[15:8] + w[7:0];
  endfunction
endpackage

// File: rtl/eel_tick.sv
module eel_tick #(
  parameter int unsigned HALF_PER = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_PER - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eel_word_reader.sv
module eel_word_reader
  import eel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              big,
  input  logic [7:0]        addr,
  input  logic              tick,
  input  logic              ee_do,
  output logic              active,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CMD_W = OPC_BITS + 8;

  rd_st_t            st;
  logic [CMD_W-1:0]  cmd;
  logic [4:0]        bitn;
  logic [4:0]        first_dat;
  logic [4:0]        last_bit;
  logic              sk_rise;
  logic              sk_fall;

  assign first_dat = 5'(OPC_BITS) + addr_bits(big);
  assign last_bit  = first_dat + 5'd15;
  assign sk_rise   = (st == RD_SHIFT) && tick && !ee_sk;
  assign sk_fall   = (st == RD_SHIFT) && tick && ee_sk;
  assign word_done = (st == RD_GAP) && tick;
  assign active    = (st != RD_IDLE);
  assign ee_di     = ee_cs & cmd[CMD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RD_IDLE;
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      cmd   <= '0;
      bitn  <= '0;
      word  <= '0;
    end else begin
      case (st)
        RD_IDLE: if (start) begin
          st    <= RD_SHIFT;
          ee_cs <= 1'b1;
          ee_sk <= 1'b0;
          bitn  <= '0;
          cmd   <= big ? {OPC_READ, addr} : {OPC_READ, addr[5:0], 2'b00};
        end
        RD_SHIFT: begin
          if (sk_rise) ee_sk <= 1'b1;
          if (sk_fall) begin
            ee_sk <= 1'b0;
            cmd   <= {cmd[CMD_W-2:0], 1'b0};
            if (bitn >= first_dat) word <= {word[WORD_W-2:0], ee_do};
            if (bitn == last_bit) begin
              st    <= RD_GAP;
              ee_cs <= 1'b0;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end
        RD_GAP: if (tick) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
  import eel_pkg::*;
#(
  parameter int unsigned HALF_PER = 63
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        size_strap,
  input  logic        ee_do,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  output logic        busy,
  output logic        done,
  output logic [7:0]  word_count,
  output logic [15:0] cfg_word,
  output logic        pwr_down,
  output logic [47:0] node_id,
  output logic        csum_ok,
  output logic        cis_we,
  output logic [6:0]  cis_addr,
  output logic [15:0] cis_data
);
  seq_st_t     st;
  logic        rst_q;
  logic        size_q;
  logic [6:0]  waddr;
  logic [7:0]  sum;
  logic        rd_active;
  logic        tick;
  logic        word_done;
  logic [15:0] rd_word;
  logic        rd_start;
  logic        in_cis;

  assign rd_start = (st == SQ_ISSUE);
  assign busy     = (st == SQ_ISSUE) || (st == SQ_WAIT);
  assign done     = (st == SQ_DONE);
  assign pwr_down = cfg_word[0];
  assign in_cis   = (waddr >= CIS_FIRST);
  assign cis_we   = (st == SQ_WAIT) && word_done && in_cis;
  assign cis_addr = waddr - CIS_FIRST;
  assign cis_data = rd_word;

  eel_tick #(.HALF_PER(HALF_PER)) tick_i (
    .clk(clk), .rst(rst), .run(rd_active), .tick(tick)
  );

  eel_word_reader rd_i (
    .clk(clk), .rst(rst), .start(rd_start), .big(size_q),
    .addr({1'b0, waddr}), .tick(tick), .ee_do(ee_do),
    .active(rd_active), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .word_done(word_done), .word(rd_word)
  );

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      size_q     <= 1'b1;
      waddr      <= '0;
      sum        <= '0;
      csum_ok    <= 1'b0;
      word_count <= '0;
      cfg_word   <= '0;
      node_id    <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (rst_q) begin
          st     <= SQ_ISSUE;
          size_q <= size_strap;
          waddr  <= '0;
          sum    <= '0;
        end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (word_done) begin
          case (waddr)
            7'd0: begin word_count <= rd_word[7:0]; sum <= byte_sum(sum, rd_word); end
            7'd1: begin cfg_word <= rd_word;        sum <= byte_sum(sum, rd_word); end
            7'd2: begin node_id[15:0]  <= rd_word;  sum <= byte_sum(sum, rd_word); end
            7'd3: begin node_id[31:16] <= rd_word;  sum <= byte_sum(sum, rd_word); end
            7'd4: begin node_id[47:32] <= rd_word;  sum <= byte_sum(sum, rd_word); end
            HDR_CSUM: csum_ok <= (sum == rd_word[15:8]);
            default: ;
          endcase
          if (waddr == last_word(size_q)) begin
            st <= SQ_DONE;
          end else begin
            st    <= SQ_ISSUE;
            waddr <= (waddr == HDR_CSUM) ? CIS_FIRST : waddr + 1'b1;
          end
        end
        SQ_DONE: st <= SQ_DONE;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eel_checker.sv
module eel_checker #(
  parameter int unsigned HALF_PER = 63
) (
  input logic clk,
  input logic rst,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic busy,
  input logic done,
  input logic cis_we,
  input logic word_done
);
  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (rst) !busy |-> !ee_cs);
  assert_di_hold_R2: assert property (@(posedge clk) disable iff (rst) (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  assert_word_end_R2: assert property (@(posedge clk) disable iff (rst) word_done |-> !ee_cs);
  assert_sk_gated_R3: assert property (@(posedge clk) disable iff (rst) !ee_cs |-> !ee_sk);
  assert_cs_gap_R3: assert property (@(posedge clk) disable iff (rst) $fell(ee_cs) |=> !ee_cs);
  assert_cis_busy_R9: assert property (@(posedge clk) disable iff (rst) cis_we |-> busy);
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst) done |=> done);
  assert_excl_R10: assert property (@(posedge clk) disable iff (rst) !(done && busy));

  generate
    if (HALF_PER > 1) begin : g_width
      assert_sk_high_R3: assert property (@(posedge clk) disable iff (rst) $rose(ee_sk) |=> ee_sk);
      assert_sk_low_R3: assert property (@(posedge clk) disable iff (rst) ($fell(ee_sk) && ee_cs) |=> !ee_sk);
    end
  endgenerate
endmodule

bind eeprom_boot_loader eel_checker #(.HALF_PER(HALF_PER)) chk_i (
  .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
  .busy(busy), .done(done), .cis_we(cis_we), .word_done(word_done)
);

// File: tb/eeprom_boot_loader_tb_top.sv
module eeprom_boot_loader_tb_top;
  localparam int HALF_TB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic size_strap = 1'b1;
  logic ee_do = 1'b1;
  logic ee_cs, ee_sk, ee_di, busy, done, pwr_down, csum_ok, cis_we;
  logic [7:0]  word_count;
  logic [15:0] cfg_word, cis_data;
  logic [47:0] node_id;
  logic [6:0]  cis_addr;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] rom [0:127];
  logic        model_big = 1'b1;
  logic [22:0] cis_q[$];
  logic [6:0]  addr_q[$];
  int          cis_seen = 0;

  always #4 clk = ~clk;

  eeprom_boot_loader #(.HALF_PER(HALF_TB)) dut_i (
    .clk(clk), .rst(rst), .size_strap(size_strap), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .busy(busy), .done(done),
    .word_count(word_count), .cfg_word(cfg_word), .pwr_down(pwr_down),
    .node_id(node_id), .csum_ok(csum_ok), .cis_we(cis_we),
    .cis_addr(cis_addr), .cis_data(cis_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial EEPROM model: command bits taken on rising SK, data driven after rising SK
  int         mcnt = 0;
  logic [2:0] mop = '0;
  logic [7:0] maddr = '0;
  always @(posedge ee_sk) if (ee_cs) begin
    int abits;
    abits = model_big ? 8 : 6;
    if (mcnt < 3) mop = {mop[1:0], ee_di};
    else if (mcnt < 3 + abits) maddr = {maddr[6:0], ee_di};
    if (mcnt == 3 + abits - 1) begin
      ee_do <= 1'b0;
      check(mop == 3'b110, "R2 opcode", 64'(mop), 64'(3'b110));
      if (addr_q.size() == 0) check(1'b0, "R4 extra read", 64'(maddr), 64'h0);
      else begin
        logic [6:0] ea;
        ea = addr_q.pop_front();
        check(maddr[6:0] == ea, "R2/R4 address", 64'(maddr), 64'(ea));
      end
    end else if (mcnt >= 3 + abits && mcnt < 3 + abits + 16) begin
      ee_do <= rom[maddr[6:0]][15 - (mcnt - 3 - abits)];
    end
    mcnt++;
  end
  always @(negedge ee_cs) begin
    mcnt = 0; mop = '0; maddr = '0; ee_do <= 1'b1;
  end

  // R3: width of each SK high phase
  int hi_run = 0;
  always @(negedge clk) begin
    if (ee_sk) hi_run++;
    else begin
      if (hi_run != 0) check(hi_run == HALF_TB, "R3 sk high width", 64'(hi_run), 64'(HALF_TB));
      hi_run = 0;
    end
  end

  // scoreboard monitor for attribute writes (R9)
  always @(negedge clk) if (!rst && cis_we) begin
    cis_seen++;
    if (cis_q.size() == 0) check(1'b0, "R9 unexpected write", 64'({cis_addr, cis_data}), 64'h0);
    else begin
      logic [22:0] e;
      e = cis_q.pop_front();
      check({cis_addr, cis_data} == e, "R9 write", 64'({cis_addr, cis_data}), 64'(e));
    end
  end

  logic [7:0] exp_sum;

  // driver: builds the image and pushes the expected items
  task automatic prepare(input bit big, input bit good, input bit pd, input logic [15:0] seed);
    int last;
    last = big ? 127 : 63;
    model_big = big;
    cis_q.delete(); addr_q.delete(); cis_seen = 0;
    for (int i = 0; i < 128; i++) rom[i] = 16'(i * 16'h3B1D) ^ seed ^ 16'(i << 9);
    rom[0][7:0] = 8'(last + 1);
    rom[1][0] = pd;
    exp_sum = 8'h00;
    for (int i = 0; i < 5; i++) exp_sum = exp_sum + rom[i][7:0] + rom[i][15:8];
    rom[5][15:8] = good ? exp_sum : (exp_sum ^ 8'h5A);
    for (int i = 0; i <= 5; i++) addr_q.push_back(7'(i));
    for (int i = 16; i <= last; i++) begin
      addr_q.push_back(7'(i));
      cis_q.push_back({7'(i - 16), rom[i]});
    end
  endtask

  task automatic run_load(input bit big, input bit good, input bit pd, input logic [15:0] seed, input bit flip);
    int n;
    prepare(big, good, pd, seed);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !ee_cs, "R1 reset state", 64'({busy, done, ee_cs}), 64'h0);
    size_strap = big;
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy after release", 64'(busy), 64'h1);
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk); n++;
      if (flip && n == 200) size_strap = ~big;
    end
    check(done == 1'b1, "R10 done reached", 64'(done), 64'h1);
    check(busy == 1'b0, "R10 busy cleared", 64'(busy), 64'h0);
    check(word_count == rom[0][7:0], "R5 word count", 64'(word_count), 64'(rom[0][7:0]));
    check(cfg_word == rom[1], "R6 cfg word", 64'(cfg_word), 64'(rom[1]));
    check(pwr_down == pd, "R6 power down", 64'(pwr_down), 64'(pd));
    check(node_id == {rom[4], rom[3], rom[2]}, "R7 node id", 64'(node_id), 64'({rom[4], rom[3], rom[2]}));
    check(node_id[7:0] == rom[2][7:0], "R7 byte0", 64'(node_id[7:0]), 64'(rom[2][7:0]));
    check(csum_ok == good, "R8 checksum flag", 64'(csum_ok), 64'(good));
    check(cis_seen == (big ? 112 : 48), "R9 write count", 64'(cis_seen), 64'(big ? 112 : 48));
    check(cis_q.size() == 0, "R9 writes left", 64'(cis_q.size()), 64'h0);
    check(addr_q.size() == 0, "R4 reads left", 64'(addr_q.size()), 64'h0);
    repeat (20) @(negedge clk);
    check(done && !busy && !ee_cs, "R10 done held", 64'({done, busy, ee_cs}), 64'h4);
  endtask

  initial begin
    run_load(1'b1, 1'b1, 1'b1, 16'hC0DE, 1'b0);
    run_load(1'b0, 1'b0, 1'b0, 16'h1234, 1'b1);
    run_load(1'b0, 1'b1, 1'b1, 16'hF00F, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog R10", 64'h0, 64'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule